// File: doc/BRIEF.md
# Cycle-Windowed Bitmap Fetch Sequencer

This block takes over the graphics memory fetches of a video controller for part of each display line. A line-cycle counter from the video timing is compared against a programmable start and stop cycle. While the block is enabled and the counter is inside that window, the block issues one memory read per cycle. Each read carries a 16-bit address and a 3-bit bank select. The returned byte goes through a small bitwise modifier and is then driven onto the video data bus together with a valid strobe.

The read address is taken from a working pointer. A write to the base register loads the pointer. After every read the pointer advances by a programmable step and wraps within its 64 KiB bank. Software configures the block through a single-cycle write port. Memory is assumed to return data one cycle after the read, so each modified byte reaches the bus two cycles after its read.

Top module: `line_fetch_sequencer`

## Requirements
- R1: After reset, no read is issued and the bus valid strobe is low. The stored start cycle is 15, the stop cycle is 55, the step is 1, the enable bit is clear, the bank is 0 and the modifier is in pass-through.
- R2: While the enable bit (bit 0 of the control register, cfg_addr 0) is clear, mem_rd_en stays low and vbus_valid never rises.
- R3: When enabled, a read is issued in exactly those cycles where start <= line_cycle < stop. The start cycle is at cfg_addr 3 and the stop cycle at cfg_addr 4. The start cycle is included and the stop cycle is excluded.
- R4: With the reset window and the block enabled, a sweep of line_cycle over 0..63 produces exactly 40 reads.
- R5: A window one cycle wide (start 20, stop 21) produces exactly one read per line.
- R6: A write to the base register (cfg_addr 1) loads the working pointer. The next read uses that value as mem_addr. A base write overrides any advance in the same cycle.
- R7: After each read the working pointer advances by the step register (cfg_addr 2), modulo 2^16, with no carry into the bank.
- R8: mem_bank equals the 3-bit bank field held in control bits [3:1] on every read.
- R9: The modifier mode is set by control bits [5:4]: 0 passes the byte, 1 inverts it, 2 XORs it with the mask register (cfg_addr 5) and 3 ANDs it with the mask.
- R10: Each read yields exactly one vbus_valid pulse, two cycles later, carrying the modified byte. Bytes leave in read order.
- R11: In cycles without a read and without a base write, the working pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| line_cycle | input | 6 | Current cycle within the display line |
| mem_rd_en | output | 1 | Memory read request for this cycle |
| mem_addr | output | 16 | Read address within the bank |
| mem_bank | output | 3 | Bank select |
| mem_rd_data | input | 8 | Byte returned one cycle after the read |
| vbus_data | output | 8 | Modified byte for the video data bus |
| vbus_valid | output | 1 | vbus_data is being driven |

## Verification
Full line sweeps run with the default window, a one-cycle window and a mid-size window. The read counts of 40, 1 and 23 distinguish an inclusive stop from an exclusive one and show whether the compare is off by one at either edge. A base near the top of the range with a step of 3 shows whether the pointer wraps correctly or leaks a carry into the bank. Lines run while the block is disabled, and again after it is re-enabled, show whether the pointer holds its value between windows. All four modifier modes are applied to the same address pattern with two different masks, so a swapped mode encoding produces a data mismatch. Changing the bank between lines shows whether the bank field reaches the read port.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
   typedef enum logic [1:0] {
      MOD_PASS = 2'd0,
      MOD_INV  = 2'd1,
      MOD_XOR  = 2'd2,
      MOD_AND  = 2'd3
   } mod_mode_e;

   localparam logic [2:0] REG_CTRL  = 3'd0;
   localparam logic [2:0] REG_BASE  = 3'd1;
   localparam logic [2:0] REG_STEP  = 3'd2;
   localparam logic [2:0] REG_START = 3'd3;
   localparam logic [2:0] REG_STOP  = 3'd4;
   localparam logic [2:0] REG_MASK  = 3'd5;
endpackage

// File: rtl/lfs_regs.sv
module lfs_regs
   import lfs_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int BANK_W    = 3,
   parameter int DATA_W    = 8,
   parameter int CYC_W     = 6,
   parameter int CFG_W     = 16,
   parameter int RST_START = 15,
   parameter int RST_STOP  = 55
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [2:0]        addr,
   input  logic [CFG_W-1:0]  wdata,
   output logic              enable,
   output logic [BANK_W-1:0] bank,
   output mod_mode_e         mode,
   output logic [ADDR_W-1:0] step,
   output logic [CYC_W-1:0]  start_cyc,
   output logic [CYC_W-1:0]  stop_cyc,
   output logic [DATA_W-1:0] mask,
   output logic              base_load,
   output logic [ADDR_W-1:0] base_val
);
   localparam int MODE_LO = BANK_W + 1;
   localparam int MODE_HI = BANK_W + 2;

   if (CFG_W < ADDR_W || CFG_W < MODE_HI + 1 || CFG_W < CYC_W || CFG_W < DATA_W) begin : g_bad_cfg
      $error("lfs_regs: CFG_W too narrow for the register fields");
   end
   if (RST_START >= (1 << CYC_W) || RST_STOP >= (1 << CYC_W)) begin : g_bad_rst
      $error("lfs_regs: reset window does not fit CYC_W");
   end

   logic wr_ctrl, wr_step, wr_start, wr_stop, wr_mask;

   always_comb begin
      wr_ctrl   = we && (addr == REG_CTRL);
      base_load = we && (addr == REG_BASE);
      wr_step   = we && (addr == REG_STEP);
      wr_start  = we && (addr == REG_START);
      wr_stop   = we && (addr == REG_STOP);
      wr_mask   = we && (addr == REG_MASK);
      base_val  = wdata[ADDR_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable    <= 1'b0;
         bank      <= '0;
         mode      <= MOD_PASS;
         step      <= ADDR_W'(1);
         start_cyc <= CYC_W'(RST_START);
         stop_cyc  <= CYC_W'(RST_STOP);
         mask      <= '0;
      end else begin
         if (wr_ctrl) begin
            enable <= wdata[0];
            bank   <= wdata[BANK_W:1];
            mode   <= mod_mode_e'(wdata[MODE_HI:MODE_LO]);
         end
         if (wr_step)  step      <= wdata[ADDR_W-1:0];
         if (wr_start) start_cyc <= wdata[CYC_W-1:0];
         if (wr_stop)  stop_cyc  <= wdata[CYC_W-1:0];
         if (wr_mask)  mask      <= wdata[DATA_W-1:0];
      end
   end
endmodule

// File: rtl/lfs_window.sv
module lfs_window #(
   parameter int CYC_W = 6
) (
   input  logic             enable,
   input  logic [CYC_W-1:0] line_cycle,
   input  logic [CYC_W-1:0] start_cyc,
   input  logic [CYC_W-1:0] stop_cyc,
   output logic             active
);
   if (CYC_W < 1) begin : g_bad
      $error("lfs_window: CYC_W must be positive");
   end

   logic past_start, before_stop;

   always_comb begin
      past_start  = (line_cycle >= start_cyc);
      before_stop = (line_cycle < stop_cyc);
      active      = enable && past_start && before_stop;
   end
endmodule

// File: rtl/lfs_addr_walker.sv
module lfs_addr_walker #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              advance,
   input  logic [ADDR_W-1:0] step,
   output logic [ADDR_W-1:0] ptr
);
   if (ADDR_W < 2) begin : g_bad
      $error("lfs_addr_walker: ADDR_W too small");
   end

   logic [ADDR_W-1:0] ptr_nxt;

   always_comb begin
      ptr_nxt = ptr + step;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       ptr <= '0;
      else if (load)    ptr <= load_val;
      else if (advance) ptr <= ptr_nxt;
   end
endmodule

// File: rtl/lfs_modifier.sv
module lfs_modifier
   import lfs_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  mod_mode_e         mode,
   input  logic [DATA_W-1:0] mask,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   for (genvar b = 0; b < DATA_W; b++) begin : g_lane
      always_comb begin
         unique case (mode)
            MOD_PASS: dout[b] = din[b];
            MOD_INV:  dout[b] = ~din[b];
            MOD_XOR:  dout[b] = din[b] ^ mask[b];
            MOD_AND:  dout[b] = din[b] & mask[b];
            default:  dout[b] = din[b];
         endcase
      end
   end
endmodule

// File: rtl/line_fetch_sequencer.sv
module line_fetch_sequencer
   import lfs_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int BANK_W    = 3,
   parameter int DATA_W    = 8,
   parameter int CYC_W     = 6,
   parameter int CFG_W     = 16,
   parameter int RST_START = 15,
   parameter int RST_STOP  = 55
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_addr,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic [CYC_W-1:0]  line_cycle,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BANK_W-1:0] mem_bank,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic [DATA_W-1:0] vbus_data,
   output logic              vbus_valid
);
   logic              enable;
   logic [BANK_W-1:0] bank;
   mod_mode_e         mode;
   logic [ADDR_W-1:0] step;
   logic [CYC_W-1:0]  start_cyc;
   logic [CYC_W-1:0]  stop_cyc;
   logic [DATA_W-1:0] mask;
   logic              base_load;
   logic [ADDR_W-1:0] base_val;
   logic              active;
   logic [ADDR_W-1:0] ptr;
   logic              ret_pend;
   logic [DATA_W-1:0] mod_byte;

   lfs_regs #(
      .ADDR_W(ADDR_W), .BANK_W(BANK_W), .DATA_W(DATA_W), .CYC_W(CYC_W),
      .CFG_W(CFG_W), .RST_START(RST_START), .RST_STOP(RST_STOP)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .enable(enable), .bank(bank), .mode(mode), .step(step),
      .start_cyc(start_cyc), .stop_cyc(stop_cyc), .mask(mask),
      .base_load(base_load), .base_val(base_val)
   );

   lfs_window #(.CYC_W(CYC_W)) u_window (
      .enable(enable), .line_cycle(line_cycle),
      .start_cyc(start_cyc), .stop_cyc(stop_cyc), .active(active)
   );

   lfs_addr_walker #(.ADDR_W(ADDR_W)) u_walker (
      .clk(clk), .rst_n(rst_n), .load(base_load), .load_val(base_val),
      .advance(active), .step(step), .ptr(ptr)
   );

   lfs_modifier #(.DATA_W(DATA_W)) u_mod (
      .mode(mode), .mask(mask), .din(mem_rd_data), .dout(mod_byte)
   );

   always_comb begin
      mem_rd_en = active;
      mem_addr  = ptr;
      mem_bank  = bank;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ret_pend   <= 1'b0;
         vbus_valid <= 1'b0;
         vbus_data  <= '0;
      end else begin
         ret_pend   <= active;
         vbus_valid <= ret_pend;
         if (ret_pend) vbus_data <= mod_byte;
      end
   end
endmodule

// File: rtl/lfs_checker.sv
module lfs_checker #(
   parameter int ADDR_W = 16,
   parameter int CYC_W  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enable,
   input logic [CYC_W-1:0]  line_cycle,
   input logic [CYC_W-1:0]  start_cyc,
   input logic [CYC_W-1:0]  stop_cyc,
   input logic              base_load,
   input logic [ADDR_W-1:0] step,
   input logic              mem_rd_en,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              vbus_valid
);
   p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> !mem_rd_en);

   p_read_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> (line_cycle >= start_cyc && line_cycle < stop_cyc));

   p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && !base_load) |=> mem_addr == $past(mem_addr) + $past(step));

   p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_rd_en && !base_load) |=> $stable(mem_addr));

   p_valid_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> ##1 vbus_valid);

   p_no_spurious_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_rd_en |=> ##1 !vbus_valid);
endmodule

bind line_fetch_sequencer lfs_checker #(.ADDR_W(ADDR_W), .CYC_W(CYC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .line_cycle(line_cycle),
   .start_cyc(start_cyc), .stop_cyc(stop_cyc), .base_load(base_load),
   .step(step), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .vbus_valid(vbus_valid)
);

// File: tb/line_fetch_sequencer_tb.sv
`timescale 1ns/1ps
module line_fetch_sequencer_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [2:0]  cfg_addr;
   logic [15:0] cfg_wdata;
   logic [5:0]  line_cycle;
   logic        mem_rd_en;
   logic [15:0] mem_addr;
   logic [2:0]  mem_bank;
   logic [7:0]  mem_rd_data;
   logic [7:0]  vbus_data;
   logic        vbus_valid;

   always #2 clk = ~clk;

   line_fetch_sequencer u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .line_cycle(line_cycle), .mem_rd_en(mem_rd_en),
      .mem_addr(mem_addr), .mem_bank(mem_bank), .mem_rd_data(mem_rd_data),
      .vbus_data(vbus_data), .vbus_valid(vbus_valid)
   );

   function automatic logic [7:0] mem_val(input logic [2:0] b, input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'(b * 29);
   endfunction

   always_ff @(posedge clk) begin
      if (mem_rd_en) mem_rd_data <= mem_val(mem_bank, mem_addr);
   end

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;
   logic [7:0] exp_q[$];

   logic        m_en;
   logic [2:0]  m_bank;
   logic [1:0]  m_mode;
   logic [15:0] m_work, m_step;
   logic [5:0]  m_start, m_stop;
   logic [7:0]  m_mask;

   task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [7:0] mod_val(input logic [7:0] d);
      case (m_mode)
         2'd0: return d;
         2'd1: return ~d;
         2'd2: return d ^ m_mask;
         default: return d & m_mask;
      endcase
   endfunction

   task automatic step_cyc(input logic [5:0] cyc, input logic we, input logic [2:0] a,
                           input logic [15:0] d, output bit rd);
      bit act;
      @(negedge clk);
      line_cycle = cyc; cfg_we = we; cfg_addr = a; cfg_wdata = d;
      #1;
      act = m_en && (cyc >= m_start) && (cyc < m_stop);
      rd = act;
      check("R3", "mem_rd_en", 32'(mem_rd_en), 32'(act));
      if (act) begin
         check("R7", "mem_addr", 32'(mem_addr), 32'(m_work));
         check("R8", "mem_bank", 32'(mem_bank), 32'(m_bank));
         exp_q.push_back(mod_val(mem_val(m_bank, m_work)));
      end
      if (we) begin
         case (a)
            3'd0: begin m_en = d[0]; m_bank = d[3:1]; m_mode = d[5:4]; end
            3'd2: m_step  = d;
            3'd3: m_start = d[5:0];
            3'd4: m_stop  = d[5:0];
            3'd5: m_mask  = d[7:0];
            default: ;
         endcase
      end
      if (we && a == 3'd1) m_work = d;
      else if (act)        m_work = m_work + m_step;
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      bit rd;
      step_cyc(6'd63, 1'b1, a, d, rd);
   endtask

   task automatic idle(input int n);
      bit rd;
      for (int i = 0; i < n; i++) step_cyc(6'd63, 1'b0, 3'd0, 16'd0, rd);
   endtask

   task automatic run_line(output int cnt);
      bit rd;
      cnt = 0;
      for (int c = 0; c < 64; c++) begin
         step_cyc(6'(c), 1'b0, 3'd0, 16'd0, rd);
         if (rd) cnt++;
      end
      idle(3);
   endtask

   // Monitor: pops the scoreboard on every valid byte
   always @(negedge clk) begin
      if (rst_n === 1'b1 && vbus_valid === 1'b1) begin
         if (exp_q.size() == 0) begin
            check("R10", "unexpected vbus_valid", 32'(1), 32'(0));
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check("R9", "vbus_data", 32'(vbus_data), 32'(e));
         end
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_fail++; n_checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      int cnt;
      rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; line_cycle = '0;
      m_en = 0; m_bank = 0; m_mode = 0; m_work = 0; m_step = 1;
      m_start = 15; m_stop = 55; m_mask = 0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      check("R1", "mem_rd_en in reset", 32'(mem_rd_en), 32'(0));
      check("R1", "vbus_valid in reset", 32'(vbus_valid), 32'(0));
      rst_n = 1'b1;

      // R2: disabled line, no reads
      run_line(cnt);
      check("R2", "reads while disabled", 32'(cnt), 32'(0));
      check("R2", "vbus_valid while disabled", 32'(vbus_valid), 32'(0));

      // R4 / R1 / R6: default window, base load
      wr(3'd1, 16'h1000);
      wr(3'd0, 16'h0001);
      run_line(cnt);
      check("R4", "default window reads", 32'(cnt), 32'(40));

      // R5: one-cycle window
      wr(3'd3, 16'd20); wr(3'd4, 16'd21);
      run_line(cnt);
      check("R5", "narrow window reads", 32'(cnt), 32'(1));

      // R3: mid window
      wr(3'd4, 16'd43);
      run_line(cnt);
      check("R3", "window 20..43 reads", 32'(cnt), 32'(23));

      // R8 / R9: bank 5 with invert
      wr(3'd0, 16'h0001 | (16'd5 << 1) | (16'd1 << 4));
      run_line(cnt);
      check("R8", "bank 5 line reads", 32'(cnt), 32'(23));

      // R9: XOR and AND with masks
      wr(3'd5, 16'h00A5);
      wr(3'd0, 16'h0001 | (16'd2 << 1) | (16'd2 << 4));
      run_line(cnt);
      wr(3'd0, 16'h0001 | (16'd7 << 1) | (16'd3 << 4));
      run_line(cnt);
      wr(3'd5, 16'h003C);
      run_line(cnt);
      check("R9", "and-mode line reads", 32'(cnt), 32'(23));

      // R7: wrap with step 3
      wr(3'd0, 16'h0001 | (16'd3 << 1));
      wr(3'd3, 16'd0); wr(3'd4, 16'd5);
      wr(3'd2, 16'd3);
      wr(3'd1, 16'hFFFE);
      run_line(cnt);
      check("R7", "wrapped pointer", 32'(m_work), 32'(16'h000D));

      // R11: disable, pointer held, then re-enable
      wr(3'd0, 16'h0000);
      run_line(cnt);
      check("R11", "reads while off", 32'(cnt), 32'(0));
      wr(3'd0, 16'h0001);
      run_line(cnt);
      check("R11", "reads after re-enable", 32'(cnt), 32'(5));

      // R6: base write in the same cycle as a read wins
      begin
         bit rd;
         wr(3'd2, 16'd1);
         step_cyc(6'd2, 1'b1, 3'd1, 16'h4000, rd);
         check("R6", "read during base write", 32'(rd), 32'(1));
         step_cyc(6'd3, 1'b0, 3'd0, 16'd0, rd);
         check("R6", "addr after base write", 32'(mem_addr), 32'(16'h4000));
         idle(4);
      end

      check("R10", "scoreboard drained", 32'(exp_q.size()), 32'(0));
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule